// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block lets a device that pulls a shared, active-low, open-drain alert line announce itself to the bus host. A pending alert is latched on the rising edge of the device's alert condition and shown as a pull-down enable on the alert line. When the host reads from the alert response address, the block acknowledges only while its own alert is pending. It then returns its own 7-bit device address as the data byte, and drives SDA as an open-drain output.

Several devices may answer at the same time, so the block compares every bit it releases with the sampled bus level. If it sends a 1 but reads a 0, it has lost arbitration. It then stops driving for the rest of the byte, so the device with the lowest address wins. The alert is released only after a winning response has been followed by a status read taken while the condition is low.

The block sits behind a bit-level bus front end, which supplies one-cycle strobes:
- start and stop conditions;
- SCL falling, the moment the block may change its SDA drive;
- bit sample, taken while SCL is high, with the sampled SDA level.

The state machine has six states:
- ST_IDLE: between transfers.
- ST_ADDR: collecting the address byte.
- ST_ACK: pulling SDA low for the acknowledge bit.
- ST_TX: shifting out the response byte.
- ST_HOSTACK: response done, waiting for the host's acknowledge and stop.
- ST_IGNORE: the address did not match or no alert is pending.

Its transitions:
- A stop goes to ST_IDLE from any state.
- A start goes to ST_ADDR from any state, and stop takes precedence.
- In ST_ADDR, once eight bits are in, the next SCL fall goes to ST_ACK on a match with a pending alert, and to ST_IGNORE otherwise.
- In ST_ACK, the next SCL fall goes to ST_TX.
- In ST_TX, the SCL fall after the last bit goes to ST_HOSTACK.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, both alert_low_o and sda_low_o are 0.
- R2: A rising edge of cond_i sets the pending alert, and alert_low_o is 1 in the following cycle. alert_low_o stays 1 after cond_i falls, until the release rule of R7 applies.
- R3: Address bits are taken MSB first, and only the byte 0x19 (address 0001100 in bits 7:1, read bit 1 in bit 0) matches. A write to that address (0x18) or a read of any other address gets no acknowledge and no SDA drive until the next start.
- R4: The block acknowledges the matching byte only while its alert is pending. It does so by pulling SDA low for the whole ninth bit.
- R5: After the acknowledge, the block sends {DEV_ADDR, 1'b1} MSB first, changing its drive only at SCL-fall strobes. With DEV_ADDR = 0x2C the byte on the bus is 0x59.
- R6: When a bit the block releases is sampled as 0, it stops driving for the rest of the byte, and the response does not count as a win. With a lower-addressed competitor (0x1A) the bus carries 0x35 and the alert stays low afterwards.
- R7: The pending alert clears only on a status_rd_i strobe that comes after a winning response, and only while cond_i is 0 in that same cycle.
- R8: A status read while cond_i is 1, or a status read with no winning response since the alert was raised, leaves alert_low_o at 1.
- R9: A start restarts address collection from any state. A stop returns the block to ST_IDLE with SDA released by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start or repeated-start strobe |
| stop_i | input | 1 | Stop strobe |
| scl_fall_i | input | 1 | SCL falling strobe; SDA drive may change |
| bit_stb_i | input | 1 | Bit sample strobe while SCL is high |
| sda_i | input | 1 | Sampled SDA level |
| cond_i | input | 1 | Alert condition from the device |
| status_rd_i | input | 1 | Strobe: device status has been read |
| sda_low_o | output | 1 | Pull SDA low (open-drain enable) |
| alert_low_o | output | 1 | Pull the alert line low (open-drain enable) |

## Verification
A wrong state or arbitration flag shows up within one bus byte, in one of two ways:
- an acknowledge bit that is missing or unexpected;
- a response byte on the wired-AND line that differs from the lower of the competing responders' bytes.

A wrong pending or success flag shows up on alert_low_o in the cycle after a condition edge or a status strobe. The bench therefore checks each transaction's acknowledge and byte through a scoreboard, and checks the alert line right after each strobe that could move it.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int unsigned SAR_ADDR_W = 7;
    localparam logic [SAR_ADDR_W-1:0] SAR_RESP_ADDR = 7'b0001100;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_ACK     = 3'd2,
        ST_TX      = 3'd3,
        ST_HOSTACK = 3'd4,
        ST_IGNORE  = 3'd5
    } sar_state_e;

endpackage

// File: rtl/sar_addr_rx.sv
module sar_addr_rx #(
    parameter int unsigned ADDR_W = 7,
    parameter logic [ADDR_W-1:0] MATCH_ADDR = 7'b0001100
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic shift_i,
    input  logic sda_i,
    output logic full_o,
    output logic match_o
);
    localparam int unsigned BYTE_W = ADDR_W + 1;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] MATCH_BYTE = {MATCH_ADDR, 1'b1};

    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (shift_i && !full_o) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        full_o  = (cnt_q == CNT_W'(BYTE_W));
        match_o = full_o && (shreg_q == MATCH_BYTE);
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= CNT_W'(BYTE_W));

endmodule

// File: rtl/sar_tx_arb.sv
module sar_tx_arb #(
    parameter int unsigned ADDR_W = 7,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2C
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    input  logic adv_i,
    input  logic active_i,
    input  logic bit_stb_i,
    input  logic sda_i,
    output logic cur_bit_o,
    output logic last_o,
    output logic lost_o
);
    localparam int unsigned BYTE_W = ADDR_W + 1;
    localparam int unsigned IDX_W  = $clog2(BYTE_W);
    localparam logic [BYTE_W-1:0] RESP = {DEV_ADDR, 1'b1};

    logic [IDX_W-1:0] idx_q;
    logic             lost_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            idx_q  <= '0;
            lost_q <= 1'b0;
        end else if (load_i) begin
            idx_q  <= IDX_W'(BYTE_W - 1);
            lost_q <= 1'b0;
        end else begin
            if (adv_i) begin
                idx_q <= idx_q - 1'b1;
            end
            if (active_i && bit_stb_i && RESP[idx_q] && !sda_i) begin
                lost_q <= 1'b1;
            end
        end
    end

    always_comb begin
        cur_bit_o = RESP[idx_q];
        last_o    = (idx_q == '0);
        lost_o    = lost_q;
    end

    // R6
    lost_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lost_q) |-> $past(active_i && bit_stb_i && !sda_i));

endmodule

// File: rtl/sar_alert_flag.sv
module sar_alert_flag (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cond_i,
    input  logic status_rd_i,
    input  logic won_i,
    output logic pending_o
);
    logic cond_q;
    logic pending_q;
    logic won_q;
    logic release_w;

    assign release_w = pending_q && won_q && status_rd_i && !cond_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cond_q    <= 1'b0;
            pending_q <= 1'b0;
            won_q     <= 1'b0;
        end else begin
            cond_q <= cond_i;
            if (cond_i && !cond_q) begin
                pending_q <= 1'b1;
            end else if (release_w) begin
                pending_q <= 1'b0;
            end
            if (release_w) begin
                won_q <= 1'b0;
            end else if (won_i && pending_q) begin
                won_q <= 1'b1;
            end
        end
    end

    assign pending_o = pending_q;

    // R2
    raise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cond_i && !cond_q) |=> pending_q);

    // R7
    release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pending_q) |-> $past(status_rd_i && !cond_i && won_q));

endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder
    import sar_pkg::*;
#(
    parameter logic [SAR_ADDR_W-1:0] DEV_ADDR = 7'h2C
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic scl_fall_i,
    input  logic bit_stb_i,
    input  logic sda_i,
    input  logic cond_i,
    input  logic status_rd_i,
    output logic sda_low_o,
    output logic alert_low_o
);
    sar_state_e state_q, state_d;

    logic rx_full, rx_match;
    logic tx_bit, tx_last, tx_lost;
    logic tx_load, tx_adv, won;
    logic pending;

    sar_addr_rx #(
        .ADDR_W     (SAR_ADDR_W),
        .MATCH_ADDR (SAR_RESP_ADDR)
    ) i_rx (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (start_i),
        .shift_i (bit_stb_i && (state_q == ST_ADDR)),
        .sda_i   (sda_i),
        .full_o  (rx_full),
        .match_o (rx_match)
    );

    sar_tx_arb #(
        .ADDR_W   (SAR_ADDR_W),
        .DEV_ADDR (DEV_ADDR)
    ) i_tx (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (tx_load),
        .adv_i     (tx_adv),
        .active_i  (state_q == ST_TX),
        .bit_stb_i (bit_stb_i),
        .sda_i     (sda_i),
        .cur_bit_o (tx_bit),
        .last_o    (tx_last),
        .lost_o    (tx_lost)
    );

    sar_alert_flag i_flag (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cond_i      (cond_i),
        .status_rd_i (status_rd_i),
        .won_i       (won),
        .pending_o   (pending)
    );

    always_comb begin
        state_d = state_q;
        tx_load = 1'b0;
        tx_adv  = 1'b0;
        won     = 1'b0;
        if (stop_i) begin
            state_d = ST_IDLE;
        end else if (start_i) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: begin
                    if (scl_fall_i && rx_full) begin
                        state_d = (rx_match && pending) ? ST_ACK : ST_IGNORE;
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        state_d = ST_TX;
                        tx_load = 1'b1;
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (tx_last) begin
                            state_d = ST_HOSTACK;
                            won     = !tx_lost;
                        end else begin
                            tx_adv = 1'b1;
                        end
                    end
                end
                ST_HOSTACK: state_d = ST_HOSTACK;
                ST_IGNORE:  state_d = ST_IGNORE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        sda_low_o   = (state_q == ST_ACK) ||
                      ((state_q == ST_TX) && !tx_bit && !tx_lost);
        alert_low_o = pending;
    end

    // R4
    ack_pending_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_ACK && $past(state_q) == ST_ADDR) |-> $past(pending));

    // R9
    stop_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(stop_i) |-> !sda_low_o);

    // R3
    ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IGNORE) |-> !sda_low_o);

endmodule

// File: tb/test_smb_alert_responder.sv
module test_smb_alert_responder;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] DUT_ADDR = 7'h2C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_s = 1'b0, stop_s = 1'b0, scl_fall = 1'b0, bit_stb = 1'b0;
    logic cond = 1'b0, status_rd = 1'b0;
    logic sda_low, alert_low;
    logic mst_sda = 1'b1, comp_low = 1'b0, comp_lost = 1'b0;
    logic sda_line;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    string      exp_tag_q[$];
    logic [8:0] exp_q[$];
    logic [8:0] obs_q[$];

    assign sda_line = mst_sda & ~sda_low & ~comp_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_alert_responder #(.DEV_ADDR(DUT_ADDR)) i_smb_alert_responder (
        .clk_i       (clk),
        .rst_i       (rst),
        .start_i     (start_s),
        .stop_i      (stop_s),
        .scl_fall_i  (scl_fall),
        .bit_stb_i   (bit_stb),
        .sda_i       (sda_line),
        .cond_i      (cond),
        .status_rd_i (status_rd),
        .sda_low_o   (sda_low),
        .alert_low_o (alert_low)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_s = 1'b1;
        @(negedge clk); start_s = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_s = 1'b1; mst_sda = 1'b1;
        @(negedge clk); stop_s = 1'b0;
    endtask

    task automatic pulse_status();
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_bit(input logic mbit, input logic cen, input logic cbit, output logic seen);
        @(negedge clk);
        mst_sda  = mbit;
        comp_low = cen & ~cbit & ~comp_lost;
        scl_fall = 1'b1;
        @(negedge clk); scl_fall = 1'b0;
        @(negedge clk); bit_stb = 1'b1;
        seen = sda_line;
        if (cen && cbit && !seen) comp_lost = 1'b1;
        @(negedge clk); bit_stb = 1'b0;
    endtask

    // driver: runs one read/write transfer and records ack and byte seen on the bus
    task automatic transact(input logic [7:0] abyte, input logic cen, input logic [6:0] caddr,
                            input string tag, input logic exp_ack, input logic [7:0] exp_data);
        logic       s;
        logic [7:0] data;
        logic [7:0] cb;
        logic       ack;
        cb = {caddr, 1'b1};
        exp_tag_q.push_back(tag);
        exp_q.push_back({exp_ack, exp_data});
        comp_lost = 1'b0;
        pulse_start();
        for (int i = 7; i >= 0; i--) do_bit(abyte[i], 1'b0, 1'b0, s);
        do_bit(1'b1, cen, 1'b0, s);
        ack = !s;
        data = '0;
        for (int i = 7; i >= 0; i--) begin
            do_bit(1'b1, cen, cb[i], s);
            data[i] = s;
        end
        do_bit(1'b1, 1'b0, 1'b0, s);
        pulse_stop();
        obs_q.push_back({ack, data});
    endtask

    // monitor: compares observed transfers against the expected queue
    initial begin
        forever begin
            @(posedge clk);
            if (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [8:0] o, e;
                string t;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = exp_tag_q.pop_front();
                checks += 2;
                if (o[8] !== e[8]) begin
                    errors++;
                    $display("FAIL %s ack: got %0b expected %0b", t, o[8], e[8]);
                end
                if (o[7:0] !== e[7:0]) begin
                    errors++;
                    $display("FAIL %s byte: got %02h expected %02h", t, o[7:0], e[7:0]);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 alert after reset", alert_low, 1'b0);
        check_bit("R1 sda after reset", sda_low, 1'b0);

        transact(8'h19, 1'b0, 7'h00, "R4 no pending", 1'b0, 8'hFF);

        cond = 1'b1;
        @(negedge clk); @(negedge clk);
        check_bit("R2 alert raised", alert_low, 1'b1);
        cond = 1'b0;
        @(negedge clk); @(negedge clk);
        check_bit("R2 alert held after cond falls", alert_low, 1'b1);

        transact(8'h18, 1'b0, 7'h00, "R3 write to response address", 1'b0, 8'hFF);
        transact(8'h59, 1'b0, 7'h00, "R3 other address", 1'b0, 8'hFF);
        transact(8'h19, 1'b0, 7'h00, "R5 sole responder", 1'b1, 8'h59);

        cond = 1'b1;
        pulse_status();
        check_bit("R8 status read with cond high", alert_low, 1'b1);
        cond = 1'b0;
        pulse_status();
        check_bit("R7 release after response", alert_low, 1'b0);

        cond = 1'b1;
        @(negedge clk); @(negedge clk);
        cond = 1'b0;
        pulse_status();
        check_bit("R8 status read without response", alert_low, 1'b1);

        transact(8'h19, 1'b1, 7'h1A, "R6 lower competitor wins", 1'b1, 8'h35);
        pulse_status();
        check_bit("R6 alert kept after lost arbitration", alert_low, 1'b1);

        pulse_start();
        for (int i = 0; i < 4; i++) do_bit(1'b0, 1'b0, 1'b0, s);
        pulse_stop();
        check_bit("R9 sda released after stop", sda_low, 1'b0);
        pulse_start();
        for (int i = 0; i < 3; i++) do_bit(1'b1, 1'b0, 1'b0, s);
        transact(8'h19, 1'b1, 7'h3F, "R9 restart then win over higher", 1'b1, 8'h59);
        pulse_status();
        check_bit("R7 release after winning", alert_low, 1'b0);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule